// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block decides, once per clock, which hardware threads of a simultaneous-multithreaded core may fetch. Each thread reports three things: whether it is active, how many instructions it now holds in the shared instruction window, and whether it is spinning on a lock. The selector grants fetch to at most two threads. It prefers threads with few instructions in flight, so that a stalled thread cannot fill the window.

A thread that is spinning on a lock is only considered after every eligible thread that is not spinning. When two or more threads are active, each one is limited to an equal share of the window, and a thread that has reached its share cannot fetch. When a single thread is active, that limit is removed and the thread may use the whole window. If threads are tied on occupancy, a rotating pointer breaks the tie. The pointer moves on by one every cycle.

The two grants are registered. The instruction-fetch stage reads them in the cycle after the inputs were sampled.

Top module: `fts_top`

## Requirements
- R1: While rst_n is low, grant0_vld_o and grant1_vld_o are 0 and the tie-break pointer is 0. The first decision after reset uses pointer value 0.
- R2: Among eligible threads, grant0 goes to the thread with the lowest occupancy and grant1 to the thread with the next-lowest occupancy.
- R3: A thread whose thr_spin_i bit is 1 is ranked after every eligible thread whose spin bit is 0, whatever the occupancies are.
- R4: When n >= 2 threads are active, a thread is eligible only if its occupancy is below floor(32/n). With 4 active threads the limit is 8, and with 3 active threads it is 10.
- R5: When exactly one thread is active, that thread is eligible while its occupancy is below 32. At 32 or more it receives no grant.
- R6: A thread whose thr_active_i bit is 0 is never granted.
- R7: The pointer starts at 0 and advances by one modulo 4 on every clock out of reset. Among threads with equal spin state and equal occupancy, the winner is the one with the smallest (id - pointer) mod 4.
- R8: If only one thread is eligible, grant1_vld_o is 0. If no thread is eligible, both valid flags are 0.
- R9: The grants are registered. Outputs seen after a clock edge reflect the inputs and pointer sampled at that edge.
- R10: When both grants are valid, they name different threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_active_i | input | 4 | Bit t is set when thread t is active |
| thr_spin_i | input | 4 | Bit t is set when thread t is spinning on a lock |
| thr_occ_i | input | 24 | Window occupancy of each thread, 6 bits per thread; thread t uses bits [6t+5:6t] |
| grant0_vld_o | output | 1 | The first grant is valid |
| grant0_id_o | output | 2 | Thread receiving the first grant |
| grant1_vld_o | output | 1 | The second grant is valid |
| grant1_id_o | output | 2 | Thread receiving the second grant |

## Verification
The bench tests occupancies that sit exactly at the share limit for three and four active threads. A design that compares with less-or-equal, or that uses the wrong divisor, would grant a thread that has already used up its share. It also tests a lone active thread at occupancies 31 and 32: a design that keeps the shared limit in force would starve that thread, and one that drops the limit entirely would grant it at 32. A spinning thread with the lowest occupancy must lose to a busier thread that is not spinning, and a design that ranks by occupancy alone would fail this. Runs of tied occupancies show whether the pointer rotates every cycle and starts from 0. A case with only one eligible thread catches a second grant that duplicates the first.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // Share of the window allowed per thread for a given active count.
  function automatic int unsigned share_cap(int unsigned depth, int unsigned n_act);
    return (n_act > 1) ? depth / n_act : depth;
  endfunction

  // Rotated distance of a thread from the tie-break pointer.
  function automatic int unsigned rot_dist(int unsigned id, int unsigned ptr, int unsigned n);
    return (id + n - ptr) % n;
  endfunction
endpackage

// File: rtl/fts_elig.sv
module fts_elig #(
  parameter int NUM_THREADS = 4,
  parameter int WIN_DEPTH   = 32,
  parameter int OCC_W       = $clog2(WIN_DEPTH) + 1,
  parameter int CNT_W       = $clog2(NUM_THREADS + 1)
) (
  input  logic [NUM_THREADS-1:0]       active_i,
  input  logic [NUM_THREADS*OCC_W-1:0] occ_i,
  output logic [NUM_THREADS-1:0]       elig_o,
  output logic [OCC_W-1:0]             cap_o,
  output logic [CNT_W-1:0]             n_act_o
);
  always_comb begin
    n_act_o = '0;
    for (int i = 0; i < NUM_THREADS; i++) n_act_o = n_act_o + CNT_W'(active_i[i]);
  end

  assign cap_o = OCC_W'(fts_pkg::share_cap(WIN_DEPTH, int'(n_act_o)));

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign elig_o[t] = active_i[t] && (occ_i[t*OCC_W +: OCC_W] < cap_o);
  end
endmodule

// File: rtl/fts_pick.sv
module fts_pick #(
  parameter int NUM_THREADS = 4,
  parameter int OCC_W       = 6,
  parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS-1:0]       cand_i,
  input  logic [NUM_THREADS-1:0]       spin_i,
  input  logic [NUM_THREADS*OCC_W-1:0] occ_i,
  input  logic [TID_W-1:0]             ptr_i,
  output logic                         vld_o,
  output logic [TID_W-1:0]             id_o
);
  localparam int KEY_W = 1 + OCC_W + TID_W;

  logic [KEY_W-1:0] key [NUM_THREADS];

  // Rank key: spin flag first, then occupancy, then rotated distance.
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_key
    assign key[t] = {spin_i[t], occ_i[t*OCC_W +: OCC_W],
                     TID_W'(fts_pkg::rot_dist(t, int'(ptr_i), NUM_THREADS))};
  end

  logic [KEY_W-1:0] best;
  always_comb begin
    best  = '1;
    id_o  = '0;
    vld_o = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (cand_i[i] && (!vld_o || key[i] < best)) begin
        best  = key[i];
        id_o  = TID_W'(i);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fts_top.sv
module fts_top #(
  parameter int NUM_THREADS = 4,
  parameter int WIN_DEPTH   = 32,
  localparam int OCC_W      = $clog2(WIN_DEPTH) + 1,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS-1:0]       thr_active_i,
  input  logic [NUM_THREADS-1:0]       thr_spin_i,
  input  logic [NUM_THREADS*OCC_W-1:0] thr_occ_i,
  output logic                         grant0_vld_o,
  output logic [TID_W-1:0]             grant0_id_o,
  output logic                         grant1_vld_o,
  output logic [TID_W-1:0]             grant1_id_o
);
  localparam int CNT_W = $clog2(NUM_THREADS + 1);

  logic [NUM_THREADS-1:0] elig, cand1, excl;
  logic [OCC_W-1:0]       cap;
  logic [CNT_W-1:0]       n_act;
  logic [TID_W-1:0]       ptr_q, pick0_id, pick1_id;
  logic                   pick0_vld, pick1_vld;

  fts_elig #(.NUM_THREADS(NUM_THREADS), .WIN_DEPTH(WIN_DEPTH), .OCC_W(OCC_W), .CNT_W(CNT_W)) elig_i (
    .active_i(thr_active_i), .occ_i(thr_occ_i), .elig_o(elig), .cap_o(cap), .n_act_o(n_act));

  fts_pick #(.NUM_THREADS(NUM_THREADS), .OCC_W(OCC_W), .TID_W(TID_W)) pick0_i (
    .cand_i(elig), .spin_i(thr_spin_i), .occ_i(thr_occ_i), .ptr_i(ptr_q),
    .vld_o(pick0_vld), .id_o(pick0_id));

  assign excl  = pick0_vld ? (NUM_THREADS'(1) << pick0_id) : '0;
  assign cand1 = elig & ~excl;

  fts_pick #(.NUM_THREADS(NUM_THREADS), .OCC_W(OCC_W), .TID_W(TID_W)) pick1_i (
    .cand_i(cand1), .spin_i(thr_spin_i), .occ_i(thr_occ_i), .ptr_i(ptr_q),
    .vld_o(pick1_vld), .id_o(pick1_id));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      grant0_vld_o <= 1'b0;
      grant0_id_o  <= '0;
      grant1_vld_o <= 1'b0;
      grant1_id_o  <= '0;
    end else begin
      ptr_q        <= (ptr_q == TID_W'(NUM_THREADS - 1)) ? '0 : ptr_q + TID_W'(1);
      grant0_vld_o <= pick0_vld;
      grant0_id_o  <= pick0_id;
      grant1_vld_o <= pick1_vld;
      grant1_id_o  <= pick1_id;
    end
  end

  // R10
  grants_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant0_vld_o && grant1_vld_o |-> grant0_id_o != grant1_id_o);

  // R8
  second_needs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant1_vld_o |-> grant0_vld_o);

  // R3
  spin_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick0_vld && thr_spin_i[pick0_id] |-> (elig & ~thr_spin_i) == '0);

  // R4
  share_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick1_vld |-> thr_occ_i[pick1_id*OCC_W +: OCC_W] < cap);

  // R5
  lone_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_act == CNT_W'(1) |-> cap == OCC_W'(WIN_DEPTH));

  // R6
  inactive_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick0_vld |-> thr_active_i[pick0_id]);

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q != TID_W'(NUM_THREADS - 1) |=> ptr_q == $past(ptr_q) + TID_W'(1));

  // R9
  grant_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick0_vld |=> grant0_vld_o && grant0_id_o == $past(pick0_id));
endmodule

// File: tb/fts_top_tb_top.sv
module fts_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  act = '0, spn = '0;
  logic [23:0] occ = '0;
  logic        g0v, g1v;
  logic [1:0]  g0i, g1i;

  always #4 clk = ~clk;

  fts_top dut_i (.clk(clk), .rst_n(rst_n), .thr_active_i(act), .thr_spin_i(spn),
    .thr_occ_i(occ), .grant0_vld_o(g0v), .grant0_id_o(g0i),
    .grant1_vld_o(g1v), .grant1_id_o(g1i));

  int    errors = 0, checks = 0;
  bit    finished = 0;
  string lbl = "R1", e_lbl = "R1";
  int    m_ptr = 0;
  bit    e0v = 0, e1v = 0;
  int    e0i = 0, e1i = 0;

  // Reference model: scores every eligible thread and keeps the two lowest.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; e0v = 0; e1v = 0; e_lbl = "R1";
    end else begin
      int n, lim, s0, s1, sc, o;
      n = 0;
      foreach (act[t]) if (act[t]) n++;
      lim = (n > 1) ? 32 / n : 32;
      s0 = 1 << 30; s1 = 1 << 30; e0v = 0; e1v = 0;
      for (int t = 0; t < 4; t++) begin
        o = int'(occ[t*6 +: 6]);
        if (act[t] && o < lim) begin
          sc = (spn[t] ? 100000 : 0) + o * 10 + ((t - m_ptr + 4) % 4);
          if (sc < s0) begin
            s1 = s0; e1i = e0i; e1v = e0v;
            s0 = sc; e0i = t; e0v = 1;
          end else if (sc < s1) begin
            s1 = sc; e1i = t; e1v = 1;
          end
        end
      end
      m_ptr = (m_ptr + 1) % 4;
      e_lbl = lbl;
    end
  end

  task automatic check_out();
    checks++;
    if (g0v !== e0v || (e0v && g0i !== 2'(e0i))) begin
      errors++;
      $display("FAIL %s grant0: got vld=%0b id=%0d, expected vld=%0b id=%0d", e_lbl, g0v, g0i, e0v, e0i);
    end
    checks++;
    if (g1v !== e1v || (e1v && g1i !== 2'(e1i))) begin
      errors++;
      $display("FAIL %s grant1: got vld=%0b id=%0d, expected vld=%0b id=%0d", e_lbl, g1v, g1i, e1v, e1i);
    end
    if (g0v && g1v) begin
      checks++;
      if (g0i == g1i) begin
        errors++;
        $display("FAIL R10 grants equal: got %0d and %0d, expected distinct", g0i, g1i);
      end
    end
  endtask

  task automatic step(input logic [3:0] a, input logic [3:0] s,
                      input int o0, input int o1, input int o2, input int o3, input string l);
    @(negedge clk);
    check_out();
    act = a; spn = s;
    occ = {6'(o3), 6'(o2), 6'(o1), 6'(o0)};
    lbl = l;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin @(negedge clk); check_out(); end
    @(negedge clk); rst_n = 1'b1;
    step(4'b1111, 4'b0000, 5, 2, 9, 7, "R2");
    step(4'b1111, 4'b0000, 6, 1, 0, 3, "R2");
    step(4'b1111, 4'b0010, 5, 2, 9, 7, "R3");
    step(4'b1111, 4'b0011, 0, 1, 7, 7, "R3");
    step(4'b1111, 4'b0000, 8, 8, 3, 12, "R4");
    step(4'b1111, 4'b0000, 7, 8, 7, 9, "R4");
    step(4'b0111, 4'b0000, 10, 9, 9, 0, "R4");
    step(4'b0100, 4'b0000, 0, 0, 31, 0, "R5");
    step(4'b0100, 4'b0000, 0, 0, 32, 0, "R5");
    step(4'b0001, 4'b0000, 40, 0, 0, 0, "R5");
    step(4'b1010, 4'b0000, 5, 0, 0, 5, "R6");
    step(4'b0000, 4'b0000, 0, 0, 0, 0, "R8");
    step(4'b1111, 4'b0000, 9, 9, 9, 9, "R8");
    for (int k = 0; k < 6; k++) step(4'b1111, 4'b0000, 4, 4, 4, 4, "R7");
    for (int k = 0; k < 4; k++) step(4'b1111, 4'b1111, 2, 2, 2, 2, "R7");
    for (int k = 0; k < 2000; k++)
      step(4'($urandom), 4'($urandom), int'($urandom % 12), int'($urandom % 12),
           int'($urandom % 34), int'($urandom % 12), "R9");
    step(4'b0000, 4'b0000, 0, 0, 0, 0, "R9");
    @(negedge clk); check_out();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end
endmodule